// File: doc/BRIEF.md
# Iterative Word Divider with Generation-Dependent Overflow Flags

This block divides a 32-bit dividend by a 16-bit divisor, treating the operands either as unsigned numbers or as two's-complement numbers, chosen per operation by a mode input. A single-cycle `start_i` pulse captures the operands. A restoring shift-and-subtract loop then works on operand magnitudes, one quotient bit per clock. The signs are applied once the loop ends. The packed result carries the remainder in bits 31..16 and the quotient in bits 15..0. Four condition flags (negative, zero, overflow, carry) go with it.

When the quotient does not fit in 16 bits, the block raises the overflow flag and keeps the previous result. How the negative and zero flags behave then depends on a 2-bit generation select. Selects 2 and 3 report overflow only. Select 0 always reports negative. Select 1 applies a finer rule, and in signed mode that rule looks at the low byte of the magnitude quotient. A zero divisor skips the loop and reports divide-by-zero one clock after the start.

The controller is a four-state machine:
- `ST_IDLE` waits for a start. It goes to `ST_ZERO` on a zero divisor and to `ST_RUN` otherwise.
- `ST_RUN` performs the 32 iterations and then goes to `ST_WRAP`.
- `ST_WRAP` writes the result and flags and returns to `ST_IDLE`.
- `ST_ZERO` reports divide-by-zero and returns to `ST_IDLE`.

Top module: `divflag_unit`

## Requirements
- R1: In unsigned mode without overflow, the result is {remainder, quotient} of floor division. N is quotient bit 15, Z is set when the quotient is 0, and V and C are 0.
- R2: In signed mode without overflow, the quotient is truncated toward zero and the remainder takes the sign of the dividend. N and Z are taken from the 16-bit quotient as in R1, and V and C are 0.
- R3: In unsigned mode, a quotient above 0xFFFF sets V and leaves the result unchanged.
- R4: In signed mode, a quotient outside -32768..32767 sets V and leaves the result unchanged. This includes 0x80000000 divided by 0xFFFF.
- R5: With generation select 0, any overflow gives N=1 and Z=0.
- R6: With generation select 1, an unsigned overflow gives N equal to dividend bit 31 and Z=0.
- R7: With generation select 1, a signed overflow where (|dividend| >> 16) >= |divisor| gives N=0 and Z=0.
- R8: With generation select 1, a signed overflow that fails the test in R7 sets Z when the low byte of |dividend|/|divisor| is 0 and sets N from bit 7 of that byte.
- R9: With generation select 2 or 3, any overflow gives N=0 and Z=0.
- R10: A zero divisor raises `dz_o` together with `done_o` one clock after the start edge. The result, N, Z and V are held, and C is cleared.
- R11: A nonzero divisor gives a one-cycle `done_o` pulse 33 clocks after the start edge, with `dz_o` low.
- R12: A start asserted while a division is in progress has no effect on that division or its result.
- R13: C is 0 after every completion.
- R14: Reset clears the result, all flags, `done_o` and `dz_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a division (sampled in idle only) |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| gen_i | input | 2 | Generation select for overflow flag rules |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 16 | Divisor |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | {remainder, quotient}, held on overflow or divide-by-zero |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |
| dz_o | output | 1 | Divide-by-zero indication, pulsed with done |

## Verification
With a nonzero divisor, the result, the four flags and `done_o` all change at the 33rd rising edge after the edge that takes the start. With a zero divisor they change at the first edge after it. The bench drives inputs and samples outputs on falling edges. It counts the edges from the start edge until `done_o` is seen, checks that count against 33 or 1, and compares every output at that same falling edge. A golden model in the bench tracks the previously committed result and flags, so that it can check the values that overflow and divide-by-zero must leave in place.

// File: rtl/divflag_pkg.sv
package divflag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WRAP = 2'd2,
        ST_ZERO = 2'd3
    } dv_state_e;

    typedef enum logic [1:0] {
        GEN_BASE = 2'd0,
        GEN_MID  = 2'd1,
        GEN_LATE = 2'd2,
        GEN_LAST = 2'd3
    } dv_gen_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } dv_flags_t;

endpackage

// File: rtl/divflag_mag.sv
// Converts operands to magnitudes and records their signs.
module divflag_mag #(
    parameter int DVD_W = 32,
    parameter int DVS_W = 16
) (
    input  logic [DVD_W-1:0] dvd_i,
    input  logic [DVS_W-1:0] dvs_i,
    input  logic             signed_i,
    output logic [DVD_W-1:0] dvd_mag_o,
    output logic [DVS_W-1:0] dvs_mag_o,
    output logic             dvd_neg_o,
    output logic             dvs_neg_o
);

    always_comb begin
        dvd_neg_o = signed_i & dvd_i[DVD_W-1];
        dvs_neg_o = signed_i & dvs_i[DVS_W-1];
        dvd_mag_o = dvd_neg_o ? (~dvd_i + 1'b1) : dvd_i;
        dvs_mag_o = dvs_neg_o ? (~dvs_i + 1'b1) : dvs_i;
    end

endmodule

// File: rtl/divflag_iter.sv
// Restoring shift-subtract datapath: one quotient bit per step.
module divflag_iter #(
    parameter int DVD_W = 32,
    parameter int DVS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [DVD_W-1:0] dvd_mag_i,
    input  logic [DVS_W-1:0] dvs_mag_i,
    output logic [DVD_W-1:0] quo_o,
    output logic [DVS_W-1:0] rem_o
);

    logic [DVS_W:0]   acc_q;
    logic [DVD_W-1:0] quo_q;
    logic [DVS_W-1:0] dvs_q;
    logic [DVS_W:0]   trial;
    logic [DVS_W+1:0] diff;
    logic             fits;

    always_comb begin
        trial = {acc_q[DVS_W-1:0], quo_q[DVD_W-1]};
        diff  = {1'b0, trial} - {2'b00, dvs_q};
        fits  = ~diff[DVS_W+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else if (load_i) begin
            acc_q <= '0;
            quo_q <= dvd_mag_i;
            dvs_q <= dvs_mag_i;
        end else if (step_i) begin
            acc_q <= fits ? diff[DVS_W:0] : trial;
            quo_q <= {quo_q[DVD_W-2:0], fits};
        end
    end

    assign quo_o = quo_q;
    assign rem_o = acc_q[DVS_W-1:0];

endmodule

// File: rtl/divflag_post.sv
// Applies signs, detects overflow and selects the flag values.
module divflag_post
    import divflag_pkg::*;
#(
    parameter int DVD_W = 32,
    parameter int DVS_W = 16
) (
    input  logic [DVD_W-1:0] quo_mag_i,
    input  logic [DVS_W-1:0] rem_mag_i,
    input  logic             signed_i,
    input  logic             dvd_neg_i,
    input  logic             dvs_neg_i,
    input  logic             dvd_top_i,
    input  dv_gen_e          gen_i,
    output logic             ovf_o,
    output logic [2*DVS_W-1:0] result_o,
    output dv_flags_t        flags_o
);

    localparam int BYTE_W = DVS_W / 2;
    localparam int HI_W   = DVD_W - DVS_W + 1;

    logic [DVD_W-1:0] quo_signed;
    logic [DVS_W-1:0] rem_signed;
    logic [HI_W-1:0]  sign_field;
    logic             ovf_uns;
    logic             ovf_sgn;
    logic             big_mag;
    logic [BYTE_W-1:0] low_byte;

    always_comb begin
        quo_signed = (dvd_neg_i ^ dvs_neg_i) ? (~quo_mag_i + 1'b1) : quo_mag_i;
        rem_signed = dvd_neg_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
        sign_field = quo_signed[DVD_W-1:DVS_W-1];
        ovf_uns    = |quo_mag_i[DVD_W-1:DVS_W];
        ovf_sgn    = !((sign_field == '0) || (sign_field == '1));
        // magnitude quotient of 2^DVS_W or more is the same test as
        // (|dividend| >> DVS_W) >= |divisor|
        big_mag    = |quo_mag_i[DVD_W-1:DVS_W];
        low_byte   = quo_mag_i[BYTE_W-1:0];
        ovf_o      = signed_i ? ovf_sgn : ovf_uns;
        result_o   = {rem_signed, quo_signed[DVS_W-1:0]};

        flags_o = '0;
        if (!ovf_o) begin
            flags_o.n = quo_signed[DVS_W-1];
            flags_o.z = (quo_signed[DVS_W-1:0] == '0);
        end else begin
            flags_o.v = 1'b1;
            unique case (gen_i)
                GEN_BASE: flags_o.n = 1'b1;
                GEN_MID: begin
                    if (!signed_i) begin
                        flags_o.n = dvd_top_i;
                    end else if (!big_mag) begin
                        flags_o.n = low_byte[BYTE_W-1];
                        flags_o.z = (low_byte == '0);
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/divflag_unit.sv
// Top: operand capture, control state machine and output registers.
module divflag_unit
    import divflag_pkg::*;
#(
    parameter int DVS_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 signed_i,
    input  logic [1:0]           gen_i,
    input  logic [2*DVS_W-1:0]   dividend_i,
    input  logic [DVS_W-1:0]     divisor_i,
    output logic                 done_o,
    output logic [2*DVS_W-1:0]   result_o,
    output logic                 flag_n_o,
    output logic                 flag_z_o,
    output logic                 flag_v_o,
    output logic                 flag_c_o,
    output logic                 dz_o
);

    localparam int DVD_W = 2 * DVS_W;
    localparam int CNT_W = $clog2(DVD_W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DVD_W - 1);

    dv_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             mode_q, dvd_neg_q, dvs_neg_q, dvd_top_q;
    dv_gen_e          gen_q;

    logic [DVD_W-1:0] dvd_mag;
    logic [DVS_W-1:0] dvs_mag;
    logic             dvd_neg, dvs_neg;
    logic [DVD_W-1:0] quo_mag;
    logic [DVS_W-1:0] rem_mag;
    logic             post_ovf;
    logic [DVD_W-1:0] post_result;
    dv_flags_t        post_flags;
    logic             dvs_zero, accept, load, step;

    assign dvs_zero = (divisor_i == '0);
    assign accept   = (state_q == ST_IDLE) && start_i;
    assign load     = accept && !dvs_zero;
    assign step     = (state_q == ST_RUN);

    divflag_mag #(.DVD_W(DVD_W), .DVS_W(DVS_W)) mag_i (
        .dvd_i     (dividend_i),
        .dvs_i     (divisor_i),
        .signed_i  (signed_i),
        .dvd_mag_o (dvd_mag),
        .dvs_mag_o (dvs_mag),
        .dvd_neg_o (dvd_neg),
        .dvs_neg_o (dvs_neg)
    );

    divflag_iter #(.DVD_W(DVD_W), .DVS_W(DVS_W)) iter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .step_i    (step),
        .dvd_mag_i (dvd_mag),
        .dvs_mag_i (dvs_mag),
        .quo_o     (quo_mag),
        .rem_o     (rem_mag)
    );

    divflag_post #(.DVD_W(DVD_W), .DVS_W(DVS_W)) post_i (
        .quo_mag_i (quo_mag),
        .rem_mag_i (rem_mag),
        .signed_i  (mode_q),
        .dvd_neg_i (dvd_neg_q),
        .dvs_neg_i (dvs_neg_q),
        .dvd_top_i (dvd_top_q),
        .gen_i     (gen_q),
        .ovf_o     (post_ovf),
        .result_o  (post_result),
        .flags_o   (post_flags)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = dvs_zero ? ST_ZERO : ST_RUN;
            ST_RUN:  if (cnt_q == LAST_STEP) state_d = ST_WRAP;
            ST_WRAP: state_d = ST_IDLE;
            ST_ZERO: state_d = ST_IDLE;
        endcase
    end

    // state register, iteration counter and captured operation attributes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            mode_q    <= 1'b0;
            dvd_neg_q <= 1'b0;
            dvs_neg_q <= 1'b0;
            dvd_top_q <= 1'b0;
            gen_q     <= GEN_BASE;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q     <= '0;
                mode_q    <= signed_i;
                dvd_neg_q <= dvd_neg;
                dvs_neg_q <= dvs_neg;
                dvd_top_q <= dividend_i[DVD_W-1];
                gen_q     <= dv_gen_e'(gen_i);
            end else if (step) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            dz_o     <= 1'b0;
            result_o <= '0;
            flag_n_o <= 1'b0;
            flag_z_o <= 1'b0;
            flag_v_o <= 1'b0;
            flag_c_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            dz_o   <= 1'b0;
            unique case (state_q)
                ST_WRAP: begin
                    done_o   <= 1'b1;
                    flag_n_o <= post_flags.n;
                    flag_z_o <= post_flags.z;
                    flag_v_o <= post_flags.v;
                    flag_c_o <= post_flags.c;
                    if (!post_ovf) result_o <= post_result;
                end
                ST_ZERO: begin
                    done_o   <= 1'b1;
                    dz_o     <= 1'b1;
                    flag_c_o <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/divflag_unit_chk.sv
module divflag_unit_chk #(
    parameter int DVS_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               done_o,
    input logic [2*DVS_W-1:0] result_o,
    input logic               flag_n_o,
    input logic               flag_z_o,
    input logic               flag_v_o,
    input logic               flag_c_o,
    input logic               dz_o
);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_dz_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        dz_o |-> done_o);

    a_r10_dz_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        dz_o |-> $stable(result_o));

    a_r13_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !flag_c_o);

    a_r3_overflow_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && flag_v_o) |-> $stable(result_o));

    a_r1_flags_follow_quotient: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !flag_v_o && !dz_o) |->
            (flag_n_o == result_o[DVS_W-1]) && (flag_z_o == (result_o[DVS_W-1:0] == '0)));

    a_r14_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !done_o);

endmodule

bind divflag_unit divflag_unit_chk #(.DVS_W(DVS_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .done_o   (done_o),
    .result_o (result_o),
    .flag_n_o (flag_n_o),
    .flag_z_o (flag_z_o),
    .flag_v_o (flag_v_o),
    .flag_c_o (flag_c_o),
    .dz_o     (dz_o)
);

// File: tb/divflag_unit_tb_top.sv
`timescale 1ns/1ps
module divflag_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        signed_i = 1'b0;
    logic [1:0]  gen_i = 2'd0;
    logic [31:0] dividend_i = '0;
    logic [15:0] divisor_i = '0;
    logic        done_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o, dz_o;
    logic [31:0] result_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] exp_res = '0;
    logic        exp_n = 0, exp_z = 0, exp_v = 0;
    logic        exp_dz = 0, exp_ovf = 0;
    string       res_tag, flg_tag;

    always #2 clk = ~clk;

    divflag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .gen_i(gen_i), .dividend_i(dividend_i), .divisor_i(divisor_i),
        .done_o(done_o), .result_o(result_o), .flag_n_o(flag_n_o),
        .flag_z_o(flag_z_o), .flag_v_o(flag_v_o), .flag_c_o(flag_c_o), .dz_o(dz_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Golden model: updates the expected committed state from the requirements.
    task automatic model(input logic [31:0] a, input logic [15:0] b,
                         input logic sm, input logic [1:0] g);
        longint q, r, ad, av, aq;
        logic [7:0] lb;
        exp_dz = 0; exp_ovf = 0;
        if (b == 0) begin
            exp_dz = 1; res_tag = "R10"; flg_tag = "R10";
            return;
        end
        if (!sm) begin
            q = longint'(a) / longint'(b);
            r = longint'(a) % longint'(b);
            exp_ovf = (q > 64'sd65535);
        end else begin
            q = longint'($signed(a)) / longint'($signed(b));
            r = longint'($signed(a)) % longint'($signed(b));
            exp_ovf = (q > 64'sd32767) || (q < -64'sd32768);
        end
        if (!exp_ovf) begin
            res_tag = sm ? "R2" : "R1";
            flg_tag = res_tag;
            exp_res = {r[15:0], q[15:0]};
            exp_n = q[15];
            exp_z = (q[15:0] == 16'h0);
            exp_v = 0;
            return;
        end
        res_tag = sm ? "R4" : "R3";
        exp_v = 1; exp_n = 0; exp_z = 0;
        case (g)
            2'd0: begin exp_n = 1; flg_tag = "R5"; end
            2'd1: begin
                if (!sm) begin
                    exp_n = a[31]; flg_tag = "R6";
                end else begin
                    ad = longint'($signed(a)); if (ad < 0) ad = -ad;
                    av = longint'($signed(b)); if (av < 0) av = -av;
                    if ((ad >> 16) >= av) begin
                        flg_tag = "R7";
                    end else begin
                        aq = ad / av;
                        lb = aq[7:0];
                        exp_z = (lb == 8'h00);
                        exp_n = lb[7];
                        flg_tag = "R8";
                    end
                end
            end
            default: flg_tag = "R9";
        endcase
    endtask

    // Issues one operation; returns clock edges from the start edge until done.
    task automatic run_op(input logic [31:0] a, input logic [15:0] b,
                          input logic sm, input logic [1:0] g, output int lat);
        dividend_i = a; divisor_i = b; signed_i = sm; gen_i = g; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 100) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_op(input logic [31:0] a, input logic [15:0] b,
                            input logic sm, input logic [1:0] g);
        int lat;
        model(a, b, sm, g);
        run_op(a, b, sm, g, lat);
        chk(exp_dz ? "R10" : "R11", "latency", 64'(lat), exp_dz ? 64'd1 : 64'd33);
        chk(res_tag, "result", 64'(result_o), 64'(exp_res));
        chk(flg_tag, "flags nzv", 64'({flag_n_o, flag_z_o, flag_v_o}),
            64'({exp_n, exp_z, exp_v}));
        chk("R13", "carry", 64'(flag_c_o), 64'd0);
        chk(exp_dz ? "R10" : "R11", "dz", 64'(dz_o), 64'(exp_dz));
        @(negedge clk);
        chk("R11", "done single pulse", 64'(done_o), 64'd0);
    endtask

    logic [31:0] dvd_set [13] = '{32'h0, 32'h1, 32'h7, 32'h0000_8000, 32'h0000_FFFF,
                                  32'h00FF_0080, 32'h00FF_FF80, 32'h1234_5678,
                                  32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
                                  32'hFFFF_8000, 32'hFFF0_0000};
    logic [15:0] dvs_set [11] = '{16'h0, 16'h1, 16'h2, 16'h3, 16'h0100, 16'h7FFF,
                                  16'h8000, 16'hFFFF, 16'hFFFE, 16'h1234, 16'h00C3};

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int lat;
        repeat (4) @(negedge clk);
        // R14: reset state
        chk("R14", "reset outputs",
            64'({done_o, dz_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o}), 64'd0);
        chk("R14", "reset result", 64'(result_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // near-exhaustive sweep over operand sets, modes and generations
        for (int m = 0; m < 2; m++)
            for (int g = 0; g < 4; g++)
                for (int i = 0; i < 13; i++)
                    for (int j = 0; j < 11; j++)
                        check_op(dvd_set[i], dvs_set[j], m[0], g[1:0]);

        // R12: a second start during a run is ignored
        model(32'h0001_0000, 16'h0010, 1'b0, 2'd0);
        dividend_i = 32'h0001_0000; divisor_i = 16'h0010; signed_i = 0; gen_i = 0;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        repeat (5) begin @(posedge clk); @(negedge clk); lat++; end
        dividend_i = 32'hFFFF_FFFF; divisor_i = 16'h0000; signed_i = 1; gen_i = 2'd2;
        start_i = 1'b1;
        @(posedge clk); @(negedge clk); lat++;
        start_i = 1'b0;
        while (!done_o && lat < 100) begin @(posedge clk); @(negedge clk); lat++; end
        chk("R12", "latency with extra start", 64'(lat), 64'd33);
        chk("R12", "result with extra start", 64'(result_o), 64'(exp_res));
        chk("R12", "dz with extra start", 64'(dz_o), 64'd0);
        repeat (3) @(negedge clk);
        chk("R12", "no second completion", 64'(done_o), 64'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule